// File: doc/BRIEF.md
# Periodic Real-Time Timeout Generator

This block raises a timeout flag at a fixed, software-selectable rate and can turn that flag into an interrupt request. A free-running counter divides the system clock by a power of two (2^13 by default). A 2-bit rate code then stretches that base period by a further 1, 2, 4 or 8. Each completed period sets the flag. Software either polls the flag or enables the interrupt, and clears the flag by writing a 1 to it through a simple write strobe.

Only reset restarts or clears the divider. Clearing the flag, changing the enable, or changing the rate code never moves the period boundaries. The time between timeouts therefore does not depend on how quickly software responds. After reset, the first timeout comes one whole period later.

Top module: `rti_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tmo_flag` and `irq` are 0.
- R2: With `rate_sel` = 00, the flag sets once every 2^BASE_LOG2 clock cycles.
- R3: Rate codes 01, 10 and 11 make the period 2, 4 and 8 times the base period.
- R4: After reset is released, the first flag sets exactly one full period later. With reset released before edge 0, that is clock edge 2^(BASE_LOG2+rate_sel).
- R5: A cycle with `clr_stb`=1 and `clr_bit`=1 clears the flag on the next edge. With `clr_bit`=0 the flag is unchanged.
- R6: If a clear write and a timeout fall on the same edge, the flag ends up set.
- R7: `irq` equals `tmo_flag` AND `irq_en` in the same cycle. With `irq_en`=0 the flag still sets, for polling, and `irq` stays 0.
- R8: Clearing the flag does not restart the period. The next timeout falls on the same boundary it would have used without the clear.
- R9: A change of `rate_sel` takes effect at the next boundary of the running divider, which keeps its count. A timeout occurs on an edge where the low BASE_LOG2+rate_sel bits of the free count are all ones.
- R10: Asserting reset mid-run clears the divider, so the next flag again comes one full period after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | RATE_W | Period stretch code: 00 ÷1, 01 ÷2, 10 ÷4, 11 ÷8 |
| irq_en | input | 1 | Interrupt enable |
| clr_stb | input | 1 | Flag write strobe |
| clr_bit | input | 1 | Flag write data; 1 clears, 0 does nothing |
| tmo_flag | output | 1 | Timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count in the divider shows at the ports as a flag edge on the wrong clock cycle, at the latest one full period after the error. Comparing every cycle against a model counter catches it within that window. A broken clear or collision path shows on the very next edge as a flag value that differs from the model. A broken enable gate shows in `irq` during the same cycle.

// File: rtl/rti_pkg.sv
package rti_pkg;
  // number of selectable stretch codes for a given code width
  function automatic int num_rates(input int rate_w);
    return 1 << rate_w;
  endfunction
  // total free-running counter width: base bits plus largest stretch exponent
  function automatic int count_width(input int base_log2, input int rate_w);
    return base_log2 + (1 << rate_w) - 1;
  endfunction
endpackage

// File: rtl/rti_divider.sv
module rti_divider #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/rti_rate_match.sv
module rti_rate_match #(
  parameter int BASE_LOG2 = 13,
  parameter int RATE_W    = 2,
  localparam int NR = rti_pkg::num_rates(RATE_W),
  localparam int CW = rti_pkg::count_width(BASE_LOG2, RATE_W)
) (
  input  logic [CW-1:0]     count,
  input  logic [RATE_W-1:0] rate,
  output logic              hit
);
  logic [NR-1:0] boundary;
  // one boundary detector per stretch code: low BASE_LOG2+i bits all ones
  for (genvar i = 0; i < NR; i++) begin : g_code
    assign boundary[i] = &count[BASE_LOG2+i-1:0];
  end
  assign hit = boundary[rate];
endmodule

// File: rtl/rti_flag.sv
module rti_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;   // timeout wins over a same-cycle clear
    else if (clr_evt) flag <= 1'b0;
  end
endmodule

// File: rtl/rti_timer.sv
module rti_timer #(
  parameter int BASE_LOG2 = 13,
  parameter int RATE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              irq_en,
  input  logic              clr_stb,
  input  logic              clr_bit,
  output logic              tmo_flag,
  output logic              irq
);
  localparam int CW = rti_pkg::count_width(BASE_LOG2, RATE_W);

  logic [CW-1:0] free_cnt;
  logic          tick_hit;
  logic          clr_req;

  rti_divider #(.CW(CW)) u_div (
    .clk   (clk),
    .rst   (rst),
    .count (free_cnt)
  );

  rti_rate_match #(.BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W)) u_match (
    .count (free_cnt),
    .rate  (rate_sel),
    .hit   (tick_hit)
  );

  assign clr_req = clr_stb & clr_bit;

  rti_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_evt (tick_hit),
    .clr_evt (clr_req),
    .flag    (tmo_flag)
  );

  assign irq = tmo_flag & irq_en;
endmodule

// File: rtl/rti_timer_chk.sv
module rti_timer_chk (
  input logic clk,
  input logic rst,
  input logic tick_hit,
  input logic clr_stb,
  input logic clr_bit,
  input logic irq_en,
  input logic tmo_flag,
  input logic irq
);
  // R6: a timeout always leaves the flag set, clear or not
  a_r6_tick_sets: assert property (@(posedge clk) disable iff (rst)
    tick_hit |=> tmo_flag);
  // R5: a clear write without a timeout drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && clr_bit && !tick_hit) |=> !tmo_flag);
  // R5: with no clear of value 1, a set flag stays set
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag && !(clr_stb && clr_bit)) |=> tmo_flag);
  // R2: the flag only rises after a divider boundary
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_hit |=> !$rose(tmo_flag));
  // R7: no request while interrupts are disabled
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);
  // R7: request present whenever flag and enable are both high
  a_r7_follow: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag && irq_en) |-> irq);
endmodule

bind rti_timer rti_timer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_hit (tick_hit),
  .clr_stb  (clr_stb),
  .clr_bit  (clr_bit),
  .irq_en   (irq_en),
  .tmo_flag (tmo_flag),
  .irq      (irq)
);

// File: tb/test_rti_timer.sv
module test_rti_timer;
  localparam int B  = 4;
  localparam int RW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic [RW-1:0] rate = '0;
  logic          en = 1'b0, stb = 1'b0, dat = 1'b0;
  logic          flag, irq;

  int checks = 0, fails = 0;
  int unsigned n = 0;     // model of the free count since reset
  bit mflag = 1'b0;
  bit done = 1'b0;

  rti_timer #(.BASE_LOG2(B), .RATE_W(RW)) i_rti_timer (
    .clk(clk), .rst(rst), .rate_sel(rate), .irq_en(en),
    .clr_stb(stb), .clr_bit(dat), .tmo_flag(flag), .irq(irq));

  function automatic bit tmo_model(int unsigned cnt, logic [RW-1:0] r);
    int unsigned m = (1 << (B + r)) - 1;
    return (cnt & m) == m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic cyc(string req, logic [RW-1:0] r, bit e, bit s, bit d);
    bit nxt;
    rate = r; en = e; stb = s; dat = d;
    if (tmo_model(n, r)) nxt = 1'b1;
    else if (s && d)     nxt = 1'b0;
    else                 nxt = mflag;
    @(posedge clk); #1;
    n++;
    mflag = nxt;
    chk(flag === mflag, req, int'(flag), int'(mflag));
    chk(irq === (mflag & e), {req, "/R7"}, int'(irq), int'(mflag & e));
  endtask

  task automatic do_reset();
    rst = 1'b1; stb = 1'b0; dat = 1'b0; en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(flag === 1'b0, "R1 flag in reset", int'(flag), 0);
    chk(irq === 1'b0, "R1 irq in reset", int'(irq), 0);
    rst = 1'b0; n = 0; mflag = 1'b0;
  endtask

  task automatic first_flag(string req, logic [RW-1:0] r);
    int k = 0;
    do begin
      cyc(req, r, 1'b1, 1'b0, 1'b0);
      k++;
    end while (!flag && k < 1000);
    chk(k == (1 << (B + r)), req, k, 1 << (B + r));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R4 / R2: first timeout at rate 00 after one full period
    first_flag("R4 first flag rate0", 2'd0);
    chk(irq === 1'b1, "R7 irq with enable", int'(irq), 1);
    // R5: write of 0 leaves flag; write of 1 clears
    cyc("R5 write zero", 2'd0, 1'b1, 1'b1, 1'b0);
    chk(flag === 1'b1, "R5 zero keeps flag", int'(flag), 1);
    cyc("R5 write one", 2'd0, 1'b1, 1'b1, 1'b1);
    chk(flag === 1'b0, "R5 one clears flag", int'(flag), 0);
    // R8: next flag still at the original boundary (model tracks it)
    for (int i = 0; i < 40; i++) cyc("R8 period kept", 2'd0, 1'b1, 1'b0, 1'b0);
    // R6: clear on the same edge as a timeout
    while (!tmo_model(n, 2'd0)) cyc("R6 approach", 2'd0, 1'b0, 1'b0, 1'b0);
    cyc("R6 collision", 2'd0, 1'b0, 1'b1, 1'b1);
    chk(flag === 1'b1, "R6 flag stays set", int'(flag), 1);
    chk(irq === 1'b0, "R7 polling irq low", int'(irq), 0);
    // R3 / R10: each longer rate from reset
    for (int r = 1; r < 4; r++) begin
      do_reset();
      first_flag("R3 stretched period", RW'(r));
      for (int i = 0; i < 3 * (1 << (B + r)); i++)
        cyc("R3 steady", RW'(r), 1'b1, (i % 7) == 0, 1'b1);
    end
    // R10: reset mid-period restarts the divider
    for (int i = 0; i < 9; i++) cyc("R10 pre", 2'd1, 1'b1, 1'b0, 1'b0);
    do_reset();
    first_flag("R10 restart", 2'd1);
    // R9: rate changes on the fly without disturbing the divider
    for (int i = 0; i < 200; i++)
      cyc("R9 rate change", (i < 100) ? 2'd0 : 2'd3, 1'b1, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [RW-1:0] r = RW'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) rate = r;
      cyc("R2 random", rate, 1'($urandom_range(0, 1)),
          ($urandom_range(0, 9) == 0), 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule